// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the control-register front end of an audio codec. A host reaches it over a simple 32-bit register bus that has a write strobe, a read strobe, a word address and data. The block holds sixteen direct 32-bit registers. The word address is the byte offset divided by four, so the sixteen words fill a 64-byte window. One direct register holds an index pointer. A second direct register is a data port into a bank of thirty-two 8-bit indirect registers, and the index picks which of them the port reaches.

Several indirect and direct locations carry their own access rules:
- One indirect register is write-only.
- Two indirect registers are fixed identification values.
- One indirect register keeps a single writable bit merged with a fixed version code.
- One direct register is locked against writes.
- One direct control register can trigger a full reset of the block from software.

Read data is registered. The interrupt output exists but stays inactive.

Top module: `codec_regfile`

## Requirements
- R1: On reset every direct register reads 0 and every indirect register reads 0, except indirect 12, which reads 0x8A, and indirect 25, which reads 0xA0.
- R2: `addr` selects direct word 0 to 15. A write to any direct word other than 1, 2 and 4 stores all 32 bits, and a read of any direct word other than 1 returns the stored 32-bit value.
- R3: Bits [4:0] of direct word 0 form the index. A write to word 1 stores `wdata[7:0]` into the indexed indirect register. A read of word 1 returns that register zero-extended to 32 bits.
- R4: A read of word 1 while the index is 3 returns 0, whatever was written there.
- R5: A write to word 1 while the index is 11 or 25 leaves the indexed register unchanged.
- R6: A write to word 1 while the index is 12 stores `(wdata[7:0] & 0x40) | 0x8A`.
- R7: Writes to direct word 2 have no effect.
- R8: A write to direct word 4 stores `wdata[6:0]` zero-extended. When `wdata[0]` is 1, all direct and indirect registers first return to their R1 values, and word 4 then takes the masked value.
- R9: `rdata` updates at the clock edge where `rd_en` is high and holds its value otherwise. A read in the same cycle as a write returns the value from before the write.
- R10: `irq` is low at all times.
- R11: `rst` is synchronous and active-high. It applies the R1 values and clears `rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 4 | Direct register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the cycle after `rd_en` |
| irq | output | 1 | Interrupt request, always low |

## Verification
A corrupted indirect byte, a lost write or a wrongly decoded index shows up only on the next read through the data port. So the bench sets the index to every value and reads it back, two cycles after the write. The same applies to a soft reset that clears too little or too much: the bench sweeps all 48 locations right after a soft reset and right after a hardware reset. A stale read register would show up as `rdata` holding the previous word on the cycle after a new read strobe. The bench checks this with back-to-back reads of different words and with a read issued in the same cycle as a write.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;
    // Default geometry
    localparam int CR_DATA_W     = 32;
    localparam int CR_NUM_DIRECT = 16;
    localparam int CR_NUM_IND    = 32;
    localparam int CR_IND_W      = 8;

    // Direct word slots with special behaviour
    localparam int IDX_SLOT    = 0;
    localparam int PORT_SLOT   = 1;
    localparam int LOCKED_SLOT = 2;
    localparam int CTRL_SLOT   = 4;

    // Indirect slots with special behaviour
    localparam int HIDDEN_IDX  = 3;
    localparam int FIXED_A_IDX = 11;
    localparam int VER_IDX     = 12;
    localparam int FIXED_B_IDX = 25;

    // Fixed codes and masks
    localparam logic [7:0] VER_CODE    = 8'h8A;
    localparam logic [7:0] ID_CODE     = 8'hA0;
    localparam logic [7:0] VER_KEEP    = 8'h40;
    localparam int         CTRL_KEEP_W = 7;
endpackage

// File: rtl/codec_ind_bank.sv
module codec_ind_bank
    import codec_regs_pkg::*;
#(
    parameter int NUM   = CR_NUM_IND,
    parameter int W     = CR_IND_W,
    parameter int IDX_W = $clog2(NUM)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     wbyte,
    output logic [W-1:0]     rbyte
);
    typedef struct packed {
        logic [NUM-1:0][W-1:0] mem;
    } ind_state_t;

    ind_state_t st_d, st_q;

    function automatic ind_state_t reset_image();
        ind_state_t img;
        for (int i = 0; i < NUM; i++) begin
            img.mem[i] = '0;
        end
        if (VER_IDX < NUM) img.mem[VER_IDX] = W'(VER_CODE);
        if (FIXED_B_IDX < NUM) img.mem[FIXED_B_IDX] = W'(ID_CODE);
        return img;
    endfunction

    always_comb begin
        st_d = st_q;
        if (sw_rst) begin
            st_d = reset_image();
        end else if (we) begin
            case (idx)
                IDX_W'(FIXED_A_IDX), IDX_W'(FIXED_B_IDX): begin
                    // locked identification bytes
                end
                IDX_W'(VER_IDX): begin
                    st_d.mem[idx] = (wbyte & W'(VER_KEEP)) | W'(VER_CODE);
                end
                default: begin
                    st_d.mem[idx] = wbyte;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= reset_image();
        else     st_q <= st_d;
    end

    assign rbyte = (idx == IDX_W'(HIDDEN_IDX)) ? '0 : st_q.mem[idx];

    // R5
    fixed_a_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (we && idx == IDX_W'(FIXED_A_IDX)) |=> $stable(st_q.mem[FIXED_A_IDX]));

    // R5
    fixed_b_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (we && idx == IDX_W'(FIXED_B_IDX)) |=> $stable(st_q.mem[FIXED_B_IDX]));

    // R6
    ver_code_chk: assert property (@(posedge clk) disable iff (rst)
        (we && idx == IDX_W'(VER_IDX))
        |=> st_q.mem[VER_IDX] == (($past(wbyte) & W'(VER_KEEP)) | W'(VER_CODE)));

    // R3
    ind_store_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !sw_rst && idx != IDX_W'(FIXED_A_IDX) && idx != IDX_W'(FIXED_B_IDX)
            && idx != IDX_W'(VER_IDX))
        |=> st_q.mem[$past(idx)] == $past(wbyte));
endmodule

// File: rtl/codec_dir_bank.sv
module codec_dir_bank
    import codec_regs_pkg::*;
#(
    parameter int NUM   = CR_NUM_DIRECT,
    parameter int W     = CR_DATA_W,
    parameter int SEL_W = $clog2(NUM)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [SEL_W-1:0]      sel,
    input  logic [W-1:0]          wdata,
    output logic [NUM-1:0][W-1:0] regs
);
    typedef struct packed {
        logic [NUM-1:0][W-1:0] regs;
    } dir_state_t;

    dir_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            case (sel)
                SEL_W'(PORT_SLOT), SEL_W'(LOCKED_SLOT): begin
                    // port writes go to the indirect bank; locked word ignores writes
                end
                SEL_W'(CTRL_SLOT): begin
                    if (wdata[0]) st_d = '0;
                    st_d.regs[CTRL_SLOT] = W'(wdata[CTRL_KEEP_W-1:0]);
                end
                default: begin
                    st_d.regs[sel] = wdata;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign regs = st_q.regs;

    // R7
    locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (we && sel == SEL_W'(LOCKED_SLOT)) |=> $stable(st_q.regs[LOCKED_SLOT]));

    // R8
    ctrl_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (we && sel == SEL_W'(CTRL_SLOT))
        |=> st_q.regs[CTRL_SLOT] == W'($past(wdata[CTRL_KEEP_W-1:0])));

    // R8
    soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (we && sel == SEL_W'(CTRL_SLOT) && wdata[0]) |=> st_q.regs[IDX_SLOT] == '0);

    // R2
    dir_store_chk: assert property (@(posedge clk) disable iff (rst)
        (we && sel != SEL_W'(PORT_SLOT) && sel != SEL_W'(LOCKED_SLOT)
            && sel != SEL_W'(CTRL_SLOT))
        |=> st_q.regs[$past(sel)] == $past(wdata));
endmodule

// File: rtl/codec_rd_mux.sv
module codec_rd_mux
    import codec_regs_pkg::*;
#(
    parameter int NUM   = CR_NUM_DIRECT,
    parameter int W     = CR_DATA_W,
    parameter int IND_W = CR_IND_W,
    parameter int SEL_W = $clog2(NUM)
) (
    input  logic [SEL_W-1:0]      sel,
    input  logic [NUM-1:0][W-1:0] dir_regs,
    input  logic [IND_W-1:0]      ind_byte,
    output logic [W-1:0]          value
);
    always_comb begin
        if (sel == SEL_W'(PORT_SLOT)) value = W'(ind_byte);
        else                          value = dir_regs[sel];
    end
endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
    import codec_regs_pkg::*;
#(
    parameter int DATA_W     = CR_DATA_W,
    parameter int NUM_DIRECT = CR_NUM_DIRECT,
    parameter int NUM_IND    = CR_NUM_IND,
    parameter int IND_W      = CR_IND_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [$clog2(NUM_DIRECT)-1:0] addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    output logic                          irq
);
    localparam int SEL_W = $clog2(NUM_DIRECT);
    localparam int IDX_W = $clog2(NUM_IND);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [NUM_DIRECT-1:0][DATA_W-1:0] dir_regs;
    logic [IDX_W-1:0]                  ind_idx;
    logic [IND_W-1:0]                  ind_byte;
    logic [DATA_W-1:0]                 rd_value;
    logic                              port_we;
    logic                              sw_rst;

    assign port_we = wr_en && (addr == SEL_W'(PORT_SLOT));
    assign sw_rst  = wr_en && (addr == SEL_W'(CTRL_SLOT)) && wdata[0];
    assign ind_idx = dir_regs[IDX_SLOT][IDX_W-1:0];

    codec_dir_bank #(
        .NUM (NUM_DIRECT),
        .W   (DATA_W)
    ) u_dir (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .sel   (addr),
        .wdata (wdata),
        .regs  (dir_regs)
    );

    codec_ind_bank #(
        .NUM (NUM_IND),
        .W   (IND_W)
    ) u_ind (
        .clk    (clk),
        .rst    (rst),
        .sw_rst (sw_rst),
        .we     (port_we),
        .idx    (ind_idx),
        .wbyte  (wdata[IND_W-1:0]),
        .rbyte  (ind_byte)
    );

    codec_rd_mux #(
        .NUM   (NUM_DIRECT),
        .W     (DATA_W),
        .IND_W (IND_W)
    ) u_mux (
        .sel      (addr),
        .dir_regs (dir_regs),
        .ind_byte (ind_byte),
        .value    (rd_value)
    );

    always_comb begin
        st_d = st_q;
        if (rd_en) st_d.rdata = rd_value;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rdata = st_q.rdata;
    assign irq   = 1'b0;

    // R4
    hidden_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == SEL_W'(PORT_SLOT) && ind_idx == IDX_W'(HIDDEN_IDX))
        |=> rdata == '0);

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    // R9
    rdata_load_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr != SEL_W'(PORT_SLOT)) |=> rdata == $past(dir_regs[addr]));
endmodule

// File: tb/sim_codec_regfile.sv
module sim_codec_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_dir [16];
    logic [7:0]  m_ind [32];

    always #2 clk = ~clk;

    codec_regfile u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_dir[i] = '0;
        for (int i = 0; i < 32; i++) m_ind[i] = '0;
        m_ind[12] = 8'h8A;
        m_ind[25] = 8'hA0;
    endtask

    task automatic model_write(input int w, input logic [31:0] d);
        int ix;
        ix = int'(m_dir[0][4:0]);
        case (w)
            1: begin
                if (ix == 12)                 m_ind[ix] = (d[7:0] & 8'h40) | 8'h8A;
                else if (ix != 11 && ix != 25) m_ind[ix] = d[7:0];
            end
            2: ;
            4: begin
                if (d[0]) model_reset();
                m_dir[4] = {25'b0, d[6:0]};
            end
            default: m_dir[w] = d;
        endcase
    endtask

    function automatic logic [31:0] model_read(input int w);
        int ix;
        ix = int'(m_dir[0][4:0]);
        if (w == 1) return (ix == 3) ? 32'h0 : {24'b0, m_ind[ix]};
        return m_dir[w];
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic do_write(input int w, input logic [31:0] d);
        @(negedge clk);
        addr = w[3:0]; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(w, d);
    endtask

    task automatic do_read(input int w, input string tag);
        logic [31:0] exp;
        exp = model_read(w);
        @(negedge clk);
        addr = w[3:0]; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, rdata, exp);
        check("R10 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic sweep_all(input string tag);
        for (int w = 0; w < 16; w++) do_read(w, tag);
        for (int i = 0; i < 32; i++) begin
            do_write(0, 32'(i));
            do_read(1, tag);
        end
    endtask

    initial begin
        logic [31:0] old_v;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values everywhere
        sweep_all("R1");

        // R2: full-width storage in plain direct words
        for (int w = 0; w < 16; w++)
            if (w != 1 && w != 2 && w != 4)
                do_write(w, 32'hA500_0000 ^ (32'(w) * 32'h0101_0101));
        for (int w = 0; w < 16; w++) do_read(w, "R2");

        // R3 R5 R6: fill every indirect slot, upper index bits set
        for (int i = 0; i < 32; i++) begin
            do_write(0, 32'hFFFF_FFE0 | 32'(i));
            do_write(1, 32'hDEAD_BE00 | 32'((i * 37 + 5) & 8'hFF));
        end
        for (int i = 0; i < 32; i++) begin
            do_write(0, 32'h1234_5660 | 32'(i));
            do_read(1, (i == 3) ? "R4" : (i == 11 || i == 25) ? "R5" :
                       (i == 12) ? "R6" : "R3");
        end
        do_write(0, 32'd12);
        do_write(1, 32'h0000_00FF);
        do_read(1, "R6");
        do_write(1, 32'h0000_0000);
        do_read(1, "R6");

        // R7: locked word
        do_write(2, 32'hFFFF_FFFF);
        do_read(2, "R7");

        // R8: masked control store without reset, then soft reset
        do_write(4, 32'hFFFF_FFFE);
        do_read(4, "R8");
        do_read(3, "R8");
        do_write(4, 32'h0000_0081);
        sweep_all("R8");

        // R9: hold, then read colliding with a write
        do_write(5, 32'h0BAD_F00D);
        do_read(5, "R9");
        repeat (3) @(negedge clk);
        check("R9 hold", rdata, 32'h0BAD_F00D);
        old_v = m_dir[5];
        @(negedge clk);
        addr = 4'd5; wdata = 32'h7777_1111; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        model_write(5, 32'h7777_1111);
        check("R9 old", rdata, old_v);
        do_read(5, "R9");

        // R11: hardware reset mid-run
        do_write(7, 32'hCAFE_0007);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R11 rdata", rdata, 32'h0);
        sweep_all("R11");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog got=running exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule